// File: doc/BRIEF.md
# Swizzled Tile Address Generator

This block walks a rectangular pixel box in raster order: rows from top to bottom, and pixels from left to right within each row. For every pixel it produces two byte addresses. The first is the pixel's place in a plain row-major image. The second is its place in an image made of 16x16-pixel tiles, stored back to back. Inside a tile the pixels are reordered by interleaving coordinate bits with XOR terms, which keeps pixels that are close in both directions close in memory.

A walk starts with a one-cycle start pulse. The box geometry, the two strides, the pixel size, the transfer direction and an optional aligned fast mode are captured at that pulse. The generator then offers one address pair per cycle on a valid/ready handshake and marks the final pixel. Configurations it cannot serve raise an error flag, and in that case no address is produced. A downstream copy engine uses the pair as its read and write addresses. In store direction, linear data is written into the tiled layout. In load direction, tiled data is read out to linear.

Top module: `swz_addr_gen`

## Requirements
- R1: The tile-local index of a pixel is the 8-bit value whose bits, from bit 7 down to bit 0, are y3, x3^y3, y2, x2^y2, y1, x1^y1, y0, x0^y0. Here x and y are the low four bits of the pixel coordinates.
- R2: The tiled byte address is (y with bits 3..0 cleared) × tile_stride + pix_bytes × (256 × (x >> 4) + tile-local index), taken modulo 2^32.
- R3: The linear byte address is (y − box_y0) × lin_stride + pix_bytes × (x − box_x0), taken modulo 2^32.
- R4: On the cycle after an accepted start, out_valid rises with the pixel (box_x0, box_y0). Each handshake advances x by one. After the rightmost column, x returns to box_x0 and y increases by one.
- R5: out_last is high only on the pixel (box_x0+box_w−1, box_y0+box_h−1). After that pixel is accepted, out_valid is low on the next cycle and stays low until a new start.
- R6: While out_valid is high and out_ready is low, every output holds its value.
- R7: With dir_store=1, out_rd_addr carries the linear address and out_wr_addr carries the tiled address. With dir_store=0, the two are swapped.
- R8: A pix_bytes value outside 1..16 sets cfg_err on the cycle after start, and out_valid stays low.
- R9: With fast_mode=1, a box_x0 or box_w that is not a multiple of 16 is flagged on cfg_err with no output. An aligned fast-mode box yields exactly the addresses of R2 and R3.
- R10: A box_w or box_h of zero is flagged on cfg_err with no output.
- R11: A start pulse during a walk has no effect on the sequence being emitted. cfg_err keeps the verdict of the last accepted start and is cleared by a valid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures the configuration and begins a walk |
| box_x0 | input | 16 | Left column of the box |
| box_y0 | input | 16 | Top row of the box |
| box_w | input | 16 | Box width in pixels |
| box_h | input | 16 | Box height in pixels |
| lin_stride | input | 32 | Byte distance between rows of the linear image |
| tile_stride | input | 32 | Byte stride of the tiled image, applied to the 16-aligned row |
| pix_bytes | input | 5 | Bytes per pixel, 1 to 16 |
| dir_store | input | 1 | 1: linear to tiled, 0: tiled to linear |
| fast_mode | input | 1 | Advance the tile base incrementally (needs a 16-aligned box) |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | An address pair is offered |
| out_x | output | 16 | Column of the current pixel |
| out_y | output | 16 | Row of the current pixel |
| out_rd_addr | output | 32 | Source byte address |
| out_wr_addr | output | 32 | Destination byte address |
| out_last | output | 1 | Current pixel is the final one of the box |
| cfg_err | output | 1 | Last accepted start had an unusable configuration |

## Verification
Two events are the most likely to collide in a single cycle. One is the row wrap, which reloads the per-row Y term, returns x to the box origin and resets the fast-mode tile base. The other is a tile crossing in x, which moves the fast-mode tile base on by one tile. Unaligned boxes are chosen so that rows end just after a tile edge and begin just before one, and a pseudo-random ready pattern lands stalls on exactly those pixels. A start pulse is also issued during a running walk, so that it can coincide with handshakes. The reference model builds each address from the bit pattern and the plain formulas and compares every offered pair on every clock, including during stalls.

// File: rtl/swz_pkg.sv
package swz_pkg;

    localparam int COORD_W   = 16;
    localparam int ADDR_W    = 32;
    localparam int BPP_W     = 5;
    localparam int MAX_BPP   = 16;
    localparam int TILE_BITS = 4;
    localparam int IDX_W     = 2 * TILE_BITS;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [BPP_W-1:0]   bpp_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [TILE_BITS-1:0] nib_t;

    typedef struct packed {
        coord_t x0;
        coord_t y0;
        coord_t w;
        coord_t h;
        addr_t  lstride;
        addr_t  tstride;
        bpp_t   bpp;
        logic   store;
        logic   fast;
    } cfg_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t col;
        coord_t row;
        idx_t   ydup;
        addr_t  tile_off;
    } pos_t;

    // Each row bit lands on both the odd and the even slot of its pair.
    function automatic idx_t dup_bits(input nib_t v);
        idx_t r;
        for (int i = 0; i < TILE_BITS; i++) begin
            r[2*i+1] = v[i];
            r[2*i]   = v[i];
        end
        return r;
    endfunction

    // Column bits go to the even slots only.
    function automatic idx_t spread_bits(input nib_t v);
        idx_t r;
        for (int i = 0; i < TILE_BITS; i++) begin
            r[2*i+1] = 1'b0;
            r[2*i]   = v[i];
        end
        return r;
    endfunction

    function automatic logic bpp_ok(input bpp_t v);
        return (v != '0) && (v <= bpp_t'(MAX_BPP));
    endfunction

    // Byte offset of the tile column holding column x.
    function automatic addr_t tile_origin(input bpp_t b, input coord_t x);
        return addr_t'(b) * (addr_t'(x >> TILE_BITS) << IDX_W);
    endfunction

endpackage

// File: rtl/swz_intra_index.sv
module swz_intra_index
    import swz_pkg::*;
(
    input  idx_t ydup,
    input  nib_t x_low,
    output idx_t idx
);
    // The odd slots take y alone, the even slots take x^y.
    assign idx = ydup ^ spread_bits(x_low);
endmodule

// File: rtl/swz_walker.sv
module swz_walker
    import swz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cfg_t cfg_in,
    input  logic advance,
    output logic active,
    output logic err,
    output logic last,
    output cfg_t cfg_q,
    output pos_t pos
);
    localparam coord_t ONE_C = coord_t'(1);

    logic   fast_misaligned;
    logic   cfg_ok;
    logic   row_end;
    coord_t next_y;
    addr_t  tile_step;

    always_comb begin
        fast_misaligned = cfg_in.fast &&
                          ((cfg_in.x0[TILE_BITS-1:0] != '0) ||
                           (cfg_in.w[TILE_BITS-1:0]  != '0));
        cfg_ok    = bpp_ok(cfg_in.bpp) && (cfg_in.w != '0) &&
                    (cfg_in.h != '0) && !fast_misaligned;
        row_end   = (pos.col == cfg_q.w - ONE_C);
        last      = row_end && (pos.row == cfg_q.h - ONE_C);
        next_y    = pos.y + ONE_C;
        tile_step = addr_t'(cfg_q.bpp) << IDX_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            err    <= 1'b0;
            cfg_q  <= '0;
            pos    <= '0;
        end else if (start && !active) begin
            cfg_q        <= cfg_in;
            err          <= !cfg_ok;
            active       <= cfg_ok;
            pos.x        <= cfg_in.x0;
            pos.y        <= cfg_in.y0;
            pos.col      <= '0;
            pos.row      <= '0;
            pos.ydup     <= dup_bits(cfg_in.y0[TILE_BITS-1:0]);
            pos.tile_off <= tile_origin(cfg_in.bpp, cfg_in.x0);
        end else if (active && advance) begin
            if (last) begin
                active <= 1'b0;
            end else if (row_end) begin
                pos.col      <= '0;
                pos.row      <= pos.row + ONE_C;
                pos.x        <= cfg_q.x0;
                pos.y        <= next_y;
                pos.ydup     <= dup_bits(next_y[TILE_BITS-1:0]);
                pos.tile_off <= tile_origin(cfg_q.bpp, cfg_q.x0);
            end else begin
                pos.col <= pos.col + ONE_C;
                pos.x   <= pos.x + ONE_C;
                if (pos.x[TILE_BITS-1:0] == '1) begin
                    pos.tile_off <= pos.tile_off + tile_step;
                end
            end
        end
    end
endmodule

// File: rtl/swz_addr_map.sv
module swz_addr_map
    import swz_pkg::*;
(
    input  bpp_t   bpp,
    input  logic   store,
    input  logic   fast,
    input  addr_t  lstride,
    input  addr_t  tstride,
    input  logic [COORD_W-TILE_BITS-1:0] x_hi,
    input  logic [COORD_W-TILE_BITS-1:0] y_hi,
    input  coord_t row,
    input  coord_t col,
    input  addr_t  tile_off,
    input  idx_t   idx,
    output addr_t  rd_addr,
    output addr_t  wr_addr
);
    addr_t bpp_a;
    addr_t row_base;
    addr_t tile_col;
    addr_t tiled;
    addr_t linear;

    always_comb begin
        bpp_a    = addr_t'(bpp);
        row_base = addr_t'({y_hi, {TILE_BITS{1'b0}}}) * tstride;
        if (fast) begin
            tile_col = tile_off + bpp_a * addr_t'(idx);
        end else begin
            tile_col = bpp_a * ((addr_t'(x_hi) << IDX_W) + addr_t'(idx));
        end
        tiled  = row_base + tile_col;
        linear = addr_t'(row) * lstride + bpp_a * addr_t'(col);
        rd_addr = store ? linear : tiled;
        wr_addr = store ? tiled  : linear;
    end
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen
    import swz_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  coord_t box_x0,
    input  coord_t box_y0,
    input  coord_t box_w,
    input  coord_t box_h,
    input  addr_t  lin_stride,
    input  addr_t  tile_stride,
    input  bpp_t   pix_bytes,
    input  logic   dir_store,
    input  logic   fast_mode,
    input  logic   out_ready,
    output logic   out_valid,
    output coord_t out_x,
    output coord_t out_y,
    output addr_t  out_rd_addr,
    output addr_t  out_wr_addr,
    output logic   out_last,
    output logic   cfg_err
);
    cfg_t cfg_in;
    cfg_t cfg_q;
    pos_t pos;
    idx_t idx;
    logic active;

    always_comb begin
        cfg_in.x0      = box_x0;
        cfg_in.y0      = box_y0;
        cfg_in.w       = box_w;
        cfg_in.h       = box_h;
        cfg_in.lstride = lin_stride;
        cfg_in.tstride = tile_stride;
        cfg_in.bpp     = pix_bytes;
        cfg_in.store   = dir_store;
        cfg_in.fast    = fast_mode;
    end

    swz_walker i_walker (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .advance (out_ready),
        .active  (active),
        .err     (cfg_err),
        .last    (out_last),
        .cfg_q   (cfg_q),
        .pos     (pos)
    );

    swz_intra_index i_index (
        .ydup  (pos.ydup),
        .x_low (pos.x[TILE_BITS-1:0]),
        .idx   (idx)
    );

    swz_addr_map i_map (
        .bpp      (cfg_q.bpp),
        .store    (cfg_q.store),
        .fast     (cfg_q.fast),
        .lstride  (cfg_q.lstride),
        .tstride  (cfg_q.tstride),
        .x_hi     (pos.x[COORD_W-1:TILE_BITS]),
        .y_hi     (pos.y[COORD_W-1:TILE_BITS]),
        .row      (pos.row),
        .col      (pos.col),
        .tile_off (pos.tile_off),
        .idx      (idx),
        .rd_addr  (out_rd_addr),
        .wr_addr  (out_wr_addr)
    );

    assign out_valid = active;
    assign out_x     = pos.x;
    assign out_y     = pos.y;
endmodule

// File: rtl/swz_addr_gen_chk.sv
module swz_addr_gen_chk
    import swz_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start,
    input logic   out_ready,
    input logic   out_valid,
    input coord_t out_x,
    input coord_t out_y,
    input addr_t  out_rd_addr,
    input addr_t  out_wr_addr,
    input logic   out_last,
    input logic   cfg_err
);
    localparam coord_t ONE_C = coord_t'(1);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y) &&
            $stable(out_rd_addr) && $stable(out_wr_addr) && $stable(out_last)));

    assert_idle_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_keeps_going_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> out_valid);

    assert_raster_step_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
            ((out_y == $past(out_y)) ? (out_x == $past(out_x) + ONE_C)
                                     : (out_y == $past(out_y) + ONE_C)));

    assert_err_silent_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !out_valid);

    assert_walk_needs_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(start));
endmodule

bind swz_addr_gen swz_addr_gen_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_x       (out_x),
    .out_y       (out_y),
    .out_rd_addr (out_rd_addr),
    .out_wr_addr (out_wr_addr),
    .out_last    (out_last),
    .cfg_err     (cfg_err)
);

// File: tb/test_swz_addr_gen.sv
module test_swz_addr_gen;
    import swz_pkg::*;

    logic   clk = 1'b0;
    logic   rst;
    logic   start;
    coord_t box_x0, box_y0, box_w, box_h;
    addr_t  lin_stride, tile_stride;
    bpp_t   pix_bytes;
    logic   dir_store, fast_mode;
    logic   out_ready = 1'b0;
    logic   out_valid;
    coord_t out_x, out_y;
    addr_t  out_rd_addr, out_wr_addr;
    logic   out_last, cfg_err;

    always #10 clk = ~clk;

    swz_addr_gen i_swz_addr_gen (
        .clk(clk), .rst(rst), .start(start),
        .box_x0(box_x0), .box_y0(box_y0), .box_w(box_w), .box_h(box_h),
        .lin_stride(lin_stride), .tile_stride(tile_stride),
        .pix_bytes(pix_bytes), .dir_store(dir_store), .fast_mode(fast_mode),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y),
        .out_rd_addr(out_rd_addr), .out_wr_addr(out_wr_addr),
        .out_last(out_last), .cfg_err(cfg_err)
    );

    typedef struct {
        longint x;
        longint y;
        longint rd;
        longint wr;
        longint last;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          rdy_mode = 0;
    int          cycles = 0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;
    bit          was_stall = 0;
    longint      prev_rd, prev_wr, prev_x;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Tile-local index built bit by bit from the stated pattern (R1).
    function automatic longint intra(input longint x, input longint y);
        longint r = 0;
        for (int i = 0; i < 4; i++) begin
            r = r | (((y >> i) & 1) << (2*i+1));
            r = r | ((((y >> i) ^ (x >> i)) & 1) << (2*i));
        end
        return r;
    endfunction

    task automatic push_box(input int x0, input int y0, input int w, input int h,
                            input longint ls, input longint ts, input int bpp,
                            input bit store);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                exp_t   e;
                longint tiled, lin;
                e.x   = x0 + c;
                e.y   = y0 + r;
                tiled = ((e.y / 16) * 16) * ts + bpp * ((e.x / 16) * 256 + intra(e.x, e.y));
                lin   = r * ls + bpp * c;
                tiled = tiled & 64'hFFFF_FFFF;
                lin   = lin & 64'hFFFF_FFFF;
                e.rd   = store ? lin : tiled;
                e.wr   = store ? tiled : lin;
                e.last = (r == h-1 && c == w-1) ? 1 : 0;
                q.push_back(e);
            end
        end
    endtask

    task automatic issue(input int x0, input int y0, input int w, input int h,
                         input longint ls, input longint ts, input int bpp,
                         input bit store, input bit fast, input bit expect_ok);
        @(negedge clk);
        box_x0 = coord_t'(x0); box_y0 = coord_t'(y0);
        box_w = coord_t'(w);   box_h = coord_t'(h);
        lin_stride = addr_t'(ls); tile_stride = addr_t'(ts);
        pix_bytes = bpp_t'(bpp); dir_store = store; fast_mode = fast;
        start = 1'b1;
        if (expect_ok) push_box(x0, y0, w, h, ls, ts, bpp, store);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || out_valid);
    endtask

    task automatic run_box(input int x0, input int y0, input int w, input int h,
                           input longint ls, input longint ts, input int bpp,
                           input bit store, input bit fast, input int mode);
        rdy_mode = mode;
        issue(x0, y0, w, h, ls, ts, bpp, store, fast, 1);
        wait_idle();
        chk("R5 idle after last pixel", longint'(out_valid), 0);
        chk("R11 err cleared by valid start", longint'(cfg_err), 0);
    endtask

    task automatic bad_box(input string req, input int x0, input int w, input int h,
                           input int bpp, input bit fast);
        issue(x0, 2, w, h, 64, 4096, bpp, 1, fast, 0);
        for (int k = 0; k < 3; k++) begin
            chk({req, " no output"}, longint'(out_valid), 0);
            chk({req, " err flag"}, longint'(cfg_err), 1);
            @(negedge clk);
        end
    endtask

    // Reference comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            finish_run();
        end
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[3] | lfsr[9]);
        if (was_stall && out_valid) begin
            chk("R6 stalled x", longint'(out_x), prev_x);
            chk("R6 stalled rd", longint'(out_rd_addr), prev_rd);
            chk("R6 stalled wr", longint'(out_wr_addr), prev_wr);
        end
        if (out_valid) begin
            if (q.size() == 0) begin
                chk("R4 unexpected pixel", 1, 0);
            end else begin
                chk("R4 x", longint'(out_x), q[0].x);
                chk("R4 y", longint'(out_y), q[0].y);
                chk("R1 R2 R3 R7 rd", longint'(out_rd_addr), q[0].rd);
                chk("R1 R2 R3 R7 wr", longint'(out_wr_addr), q[0].wr);
                chk("R5 last", longint'(out_last), q[0].last);
                if (out_ready) void'(q.pop_front());
            end
        end
        was_stall = out_valid && !out_ready;
        prev_x  = longint'(out_x);
        prev_rd = longint'(out_rd_addr);
        prev_wr = longint'(out_wr_addr);
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        box_x0 = '0; box_y0 = '0; box_w = '0; box_h = '0;
        lin_stride = '0; tile_stride = '0; pix_bytes = '0;
        dir_store = 1'b0; fast_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset valid low", longint'(out_valid), 0);
        chk("reset err low", longint'(cfg_err), 0);

        // R1: one full tile, 1 byte per pixel, so tiled address = index
        run_box(0, 0, 16, 16, 16, 16, 1, 1, 0, 0);
        // R2 R3: unaligned origin crossing two tile columns and a tile row, load
        run_box(13, 14, 21, 5, 200, 1024, 4, 0, 0, 1);
        // R7: odd pixel size, store
        run_box(30, 3, 7, 3, 96, 512, 3, 1, 0, 1);
        // R9: aligned fast mode against the same formulas
        run_box(16, 15, 32, 2, 512, 2048, 16, 1, 1, 1);
        run_box(16, 15, 32, 2, 512, 2048, 16, 0, 0, 1);

        bad_box("R8 bpp zero", 0, 4, 4, 0, 0);
        run_box(1, 1, 3, 2, 40, 256, 2, 1, 0, 1);
        bad_box("R8 bpp seventeen", 0, 4, 4, 17, 0);
        bad_box("R9 fast unaligned x0", 8, 16, 1, 4, 1);
        bad_box("R9 fast unaligned width", 16, 24, 1, 4, 1);
        bad_box("R10 zero width", 0, 0, 4, 4, 0);
        bad_box("R10 zero height", 0, 4, 0, 4, 0);

        // R11: start during a walk is ignored
        rdy_mode = 1;
        issue(5, 9, 12, 3, 80, 768, 2, 0, 0, 1);
        repeat (4) @(negedge clk);
        issue(0, 0, 2, 2, 8, 64, 0, 1, 0, 0);
        wait_idle();
        chk("R11 no extra output after ignored start", longint'(out_valid), 0);
        chk("R11 err unchanged by ignored start", longint'(cfg_err), 0);

        // R5: single-pixel box is first and last at once
        run_box(17, 33, 1, 1, 4, 128, 5, 1, 0, 1);

        finish_run();
    end
endmodule